// File: doc/BRIEF.md
# Logistic Activation Lookup Unit

This block returns the logistic sigmoid of a signed fixed-point sample in one ROM read. It is meant to sit at the end of a neuron's accumulate path. The input is a two's-complement Q4.11 value with a valid strobe. The output is an unsigned 8-bit fraction, where code `k` stands for `k/256`, with its own valid strobe that follows two clock cycles later.

The ROM holds only the non-negative half of the curve. It covers magnitudes from 0 up to, but not including, 8 in 2048 steps of 1/256. Its contents come from an integer recurrence evaluated at elaboration, so no file is needed. A negative sample reuses the entry for its magnitude through the point symmetry of the curve about (0, 0.5): the result is 256 minus the entry. Samples whose magnitude reaches 8 skip the table and clamp to the nearest end of the output range.

Top module: `sigmoid_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, `outValid` is 0 and `outData` is 0.
- R2: `outValid` equals `inValid` delayed by exactly two clock cycles. Each valid output belongs to the sample that was presented two cycles earlier.
- R3: For a sample s with 0 < s < 8, the table address is the magnitude truncated to a multiple of 1/256 (input bits [13:3]). The output is round(256 / (1 + e^(-a/256))) for that address a, limited to 255.
- R4: A sample of exactly zero returns 0x80.
- R5: For a sample s with -8 < s < 0, the output is 256 minus the R3 table value for the magnitude |s|.
- R6: Any sample of +8 or more (code 0x4000 to 0x7FFF) returns 0xFF.
- R7: Any sample of -8 or less (code 0x8000 to 0xC000) returns 0x00. This includes the most negative code 0x8000, whose absolute value does not fit the input width.
- R8: For every input code, the output differs from the true sigmoid of the sample by no more than 0.005.
- R9: `outData` keeps its last value on any cycle where `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inData` as a sample to convert |
| inData | input | 16 | Signed Q4.11 sample |
| outValid | output | 1 | Marks `outData` as a result |
| outData | output | 8 | Unsigned sigmoid result, value = code/256 |

## Verification
The bench pushes every one of the 65536 input codes through the unit, with idle cycles mixed in. It compares each result with a table it computes in floating point and with the true curve. This covers the seam at zero, where a wrong sign path would give 0x80 as 0x7F or 0x81. It covers the last table step below 8 and the first saturated code, where a misplaced saturation bit would either wrap back to 0.5 or clamp too early. It covers the code 0x8000: a naive absolute value turns this into a large positive magnitude that would give 0xFF instead of 0x00. The idle cycles expose a valid strobe delayed by the wrong number of stages, and an output register that updates without a valid sample.

// File: rtl/sigmoid_pkg.sv
package sigmoid_pkg;

  // Enables the control path hands to the datapath each cycle
  typedef struct packed {
    logic stage1En;
    logic stage2En;
  } sigStrobes_t;

  // e^(-2^-stepLog2) as an unsigned Q32 value, from a short Taylor series
  function automatic logic [63:0] expStepQ32(input int stepLog2);
    logic [63:0] term;
    logic [63:0] acc;
    term = 64'd1 << 32;
    acc  = term;
    for (int n = 1; n <= 6; n++) begin
      term = (term >> stepLog2) / 64'(n);
      if (n % 2 == 1) acc = acc - term;
      else            acc = acc + term;
    end
    return acc;
  endfunction

endpackage

// File: rtl/sigmoid_ctrl.sv
module sigmoid_ctrl (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  output sigmoid_pkg::sigStrobes_t strobes,
  output logic                     outValid
);

  logic [1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[0], inValid};
    end
  end

  always_comb begin
    strobes.stage1En = inValid;
    strobes.stage2En = validPipe[0];
  end

  assign outValid = validPipe[1];

endmodule

// File: rtl/sigmoid_datapath.sv
module sigmoid_datapath #(
  parameter int IN_INT     = 4,
  parameter int IN_FRAC    = 11,
  parameter int RANGE_LOG2 = 3,
  parameter int ADDR_W     = 11,
  parameter int OUT_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  sigmoid_pkg::sigStrobes_t    strobes,
  input  logic [IN_INT+IN_FRAC:0]     inData,
  output logic [OUT_W-1:0]            outData
);

  localparam int IN_W      = 1 + IN_INT + IN_FRAC;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int LSB_POS   = IN_FRAC + RANGE_LOG2 - ADDR_W;
  localparam int STEP_LOG2 = ADDR_W - RANGE_LOG2;
  localparam int OUTER_W   = ADDR_W / 2;
  localparam int INNER_W   = ADDR_W - OUTER_W;

  // Entry a holds round(2^OUT_W / (1 + e^(-a * 2^-STEP_LOG2))), clamped.
  // e^(-a*step) is carried as a Q32 product that is advanced one step per entry.
  function automatic logic [OUT_W*DEPTH-1:0] buildTable();
    logic [OUT_W*DEPTH-1:0] tbl;
    logic [127:0] expVal;
    logic [127:0] stepMul;
    logic [127:0] den;
    logic [127:0] num;
    logic [127:0] quo;
    int idx;
    tbl     = '0;
    stepMul = 128'(sigmoid_pkg::expStepQ32(STEP_LOG2));
    expVal  = 128'd1 << 32;
    for (int hi = 0; hi < (1 << OUTER_W); hi++) begin
      for (int lo = 0; lo < (1 << INNER_W); lo++) begin
        idx = hi * (1 << INNER_W) + lo;
        den = (128'd1 << 32) + expVal;
        num = (128'd1 << (OUT_W + 32)) + (den >> 1);
        quo = num / den;
        if (quo > 128'((1 << OUT_W) - 1)) quo = 128'((1 << OUT_W) - 1);
        tbl[idx*OUT_W +: OUT_W] = OUT_W'(quo);
        expVal = (expVal * stepMul) >> 32;
      end
    end
    return tbl;
  endfunction

  localparam logic [OUT_W*DEPTH-1:0] ROM_BITS = buildTable();

  // Stage 1: magnitude, range test and table address
  logic              isNeg;
  logic [IN_W-1:0]   magnitude;
  logic [IN_W-1:0]   magShifted;
  logic              overRange;

  always_comb begin
    isNeg      = inData[IN_W-1];
    // 0x8000 negates to itself; read as unsigned its top bit marks it out of range
    magnitude  = isNeg ? (~inData + 1'b1) : inData;
    magShifted = magnitude >> LSB_POS;
    overRange  = |magShifted[IN_W-1:ADDR_W];
  end

  logic              negQ;
  logic              satQ;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      negQ  <= 1'b0;
      satQ  <= 1'b0;
      addrQ <= '0;
    end else if (strobes.stage1En) begin
      negQ  <= isNeg;
      satQ  <= overRange;
      addrQ <= magShifted[ADDR_W-1:0];
    end
  end

  // Stage 2: single ROM read, symmetry fix-up, saturation
  logic [OUT_W-1:0] romWord;
  logic [OUT_W-1:0] mirrored;
  logic [OUT_W-1:0] resultNext;

  always_comb begin
    romWord    = ROM_BITS[addrQ*OUT_W +: OUT_W];
    // Entries never fall below half scale, so the wrap-around difference is 2^OUT_W - entry
    mirrored   = OUT_W'(0) - romWord;
    if (satQ)       resultNext = negQ ? '0 : '1;
    else if (negQ)  resultNext = mirrored;
    else            resultNext = romWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
    end else if (strobes.stage2En) begin
      outData <= resultNext;
    end
  end

endmodule

// File: rtl/sigmoid_unit.sv
module sigmoid_unit #(
  parameter int IN_INT     = 4,
  parameter int IN_FRAC    = 11,
  parameter int RANGE_LOG2 = 3,
  parameter int ADDR_W     = 11,
  parameter int OUT_W      = 8,
  localparam int IN_W      = 1 + IN_INT + IN_FRAC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);

  sigmoid_pkg::sigStrobes_t strobes;

  sigmoid_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  sigmoid_datapath #(
    .IN_INT     (IN_INT),
    .IN_FRAC    (IN_FRAC),
    .RANGE_LOG2 (RANGE_LOG2),
    .ADDR_W     (ADDR_W),
    .OUT_W      (OUT_W)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/sigmoid_unit_chk.sv
module sigmoid_unit_chk #(
  parameter int IN_INT     = 4,
  parameter int IN_FRAC    = 11,
  parameter int RANGE_LOG2 = 3,
  parameter int OUT_W      = 8,
  localparam int IN_W      = 1 + IN_INT + IN_FRAC
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [IN_W-1:0]  inData,
  input logic             outValid,
  input logic [OUT_W-1:0] outData
);

  localparam int SAT_LIM = 1 << (IN_FRAC + RANGE_LOG2);

  // Cycles since reset release, saturating at 2, so $past never reaches into reset
  logic [1:0] armCnt;
  always_ff @(posedge clk) begin
    if (rst)                armCnt <= '0;
    else if (armCnt != 2'd2) armCnt <= armCnt + 2'd1;
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (armCnt == 2'd2) |-> (outValid == $past(inValid, 2)));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (armCnt != 2'd0 && !outValid) |-> $stable(outData));

  a_r4_zero_half: assert property (@(posedge clk) disable iff (rst)
    (armCnt == 2'd2 && $past(inValid, 2) && ($past(inData, 2) == '0))
      |-> (outData == OUT_W'(1 << (OUT_W - 1))));

  a_r6_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (armCnt == 2'd2 && $past(inValid, 2) && ($signed($past(inData, 2)) >= SAT_LIM))
      |-> (outData == '1));

  a_r7_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (armCnt == 2'd2 && $past(inValid, 2) && ($signed($past(inData, 2)) <= -SAT_LIM))
      |-> (outData == '0));

endmodule

bind sigmoid_unit sigmoid_unit_chk #(
  .IN_INT     (IN_INT),
  .IN_FRAC    (IN_FRAC),
  .RANGE_LOG2 (RANGE_LOG2),
  .OUT_W      (OUT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inData   (inData),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/sigmoid_unit_bench.sv
`timescale 1ns/1ps
module sigmoid_unit_bench;

  localparam int IN_W     = 16;
  localparam int OUT_W    = 8;
  localparam int STEP     = 256;    // table steps per unit of input
  localparam int SUB      = 8;      // input codes per table step
  localparam int SAT_CODE = 16384;  // code of +8.0
  localparam real IN_SCALE = 2048.0;

  logic             clk = 1'b0;
  logic             rst;
  logic             inValid;
  logic [IN_W-1:0]  inData;
  logic             outValid;
  logic [OUT_W-1:0] outData;

  always #2 clk = ~clk;

  sigmoid_unit u_sigmoid_unit (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Accepted codes for table entry a; both neighbours when the exact value sits on a half
  function automatic void tabRef(input int a, output int lo, output int hi);
    real y;
    real fr;
    int  f;
    y  = 256.0 / (1.0 + $exp(-real'(a) / real'(STEP)));
    f  = int'($floor(y));
    fr = y - $floor(y);
    if (fr > 0.501)      begin lo = f + 1; hi = f + 1; end
    else if (fr < 0.499) begin lo = f;     hi = f;     end
    else                 begin lo = f;     hi = f + 1; end
    if (lo > 255) lo = 255;
    if (hi > 255) hi = 255;
  endfunction

  function automatic void refCode(input logic [IN_W-1:0] code, output int lo,
                                  output int hi, output string req);
    int s;
    int m;
    int tl;
    int th;
    s = int'($signed(code));
    if (s >= SAT_CODE) begin
      lo = 255; hi = 255; req = "R6";
    end else if (s <= -SAT_CODE) begin
      lo = 0; hi = 0; req = "R7";
    end else begin
      m = (s < 0) ? -s : s;
      tabRef(m / SUB, tl, th);
      if (s < 0) begin
        lo = 256 - th; hi = 256 - tl; req = "R5";
      end else begin
        lo = tl; hi = th; req = (s == 0) ? "R4" : "R3";
      end
    end
  endfunction

  // Two-deep model of samples in flight
  bit               hv1 = 1'b0;
  bit               hv2 = 1'b0;
  logic [IN_W-1:0]  hd1 = '0;
  logic [IN_W-1:0]  hd2 = '0;
  logic [OUT_W-1:0] lastOut = '0;

  task automatic step(input bit v, input logic [IN_W-1:0] d);
    int    lo;
    int    hi;
    string req;
    real   trueVal;
    real   err;
    @(negedge clk);
    check(outValid == hv2, "R2", "valid delay", int'(outValid), int'(hv2));
    if (hv2) begin
      refCode(hd2, lo, hi, req);
      check(int'(outData) >= lo && int'(outData) <= hi, req, "table value",
            int'(outData), lo);
      trueVal = 1.0 / (1.0 + $exp(-real'($signed(hd2)) / IN_SCALE));
      err     = real'(outData) / 256.0 - trueVal;
      check(err <= 0.005 && err >= -0.005, "R8", "error bound",
            int'(outData), int'($floor(trueVal * 256.0 + 0.5)));
    end else begin
      check(outData == lastOut, "R9", "hold when idle", int'(outData), int'(lastOut));
    end
    lastOut = outData;
    hv2 = hv1; hd2 = hd1;
    hv1 = v;   hd1 = d;
    inValid = v;
    inData  = d;
  endtask

  initial begin
    rst     = 1'b1;
    inValid = 1'b0;
    inData  = '0;
    repeat (4) @(negedge clk);
    // R1: state while reset is held
    check(outValid == 1'b0, "R1", "valid in reset", int'(outValid), 0);
    check(outData == '0, "R1", "data in reset", int'(outData), 0);
    rst = 1'b0;
    // R1: first cycle after release, then the full sweep with idle gaps
    for (int i = 0; i < 65536; i++) begin
      if (i % 11 == 3) step(1'b0, IN_W'(i * 7 + 1));
      step(1'b1, IN_W'(i));
    end
    for (int k = 0; k < 4; k++) step(1'b0, IN_W'(k));
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule